// File: doc/BRIEF.md
# Video Line Timing Generator

This block produces the frame and line framing for a camera-style transmit interface. It runs on the transmit pixel clock. Each cycle it drives a frame strobe (`vsync`), a line strobe (`hsync`) and a word-valid strobe (`valid`). It pulls one packed pixel word from an upstream source in every cycle that `valid` is high. Programmable inputs set the line sync gap, the horizontal back and front porches, and the vertical sync, back porch, active and front porch line counts. A separate request port sets the number of active words per line. All timing inputs are latched once per frame, so changes made mid-frame wait for the next frame.

The horizontal resolution can be changed between frames. A request is held until the next frame boundary. In the frame that takes it, the block places dummy line pulses in the vertical sync region. It switches `hres_out` when the first dummy pulse ends. During the first dummy pulse it drives an active-low reset request for the downstream packet controller. The data-type output follows its request input only at points in the line sync gap, so it never moves while a line is open.

The upstream port has ready-only semantics. `src_rd` high means the word on `src_data` is taken in that cycle. There is no back-pressure in either direction. The source must present a fresh word in every cycle `src_rd` is high, because a line cannot stall once it has started.

Top module: `line_frame_gen`

## Requirements
- R1: While `rst_n` is low, `vsync`, `hsync`, `valid` and `src_rd` are 0, `ctl_rst_n` is 1, `hres_out` equals the parameter `DEF_HRES` and `type_out` is 0.
- R2: Every line lasts S+B+H+F cycles, where S, B and F are the latched sync gap, back porch and front porch and H is `hres_out`. Cycles are counted from 0 at the line start. `hsync` is low in cycles 0..S-1 of every line. On a pulsed line, `hsync` is high from cycle S to the end of the line. On an active line, `valid` is high exactly in cycles S+B..S+B+H-1, so it stays high without a gap for H words.
- R3: A programmed sync gap, back porch or front porch below 2 is raised to 2. No line ever has fewer than 2 cycles of `hsync` low, of porch before `valid`, or of porch after `valid`.
- R4: A frame is made of the sync region (`vsync` low), then the back porch, active and front porch regions (`vsync` high). Each region lasts its latched line count, and a count below 1 is raised to 1. Only active-region lines carry `valid`. Outside a resolution switch, only active-region lines pulse `hsync`. This guarantees at least 3 blanking lines per frame.
- R5: `src_rd` equals `valid` in every cycle. `data_out` equals `src_data` when `valid` is high and 0 otherwise.
- R6: `type_out` takes `type_req` only at a clock edge that ends a cycle whose line position p satisfies p+1 < S. It therefore never changes while `hsync` is high, and it is stable in the cycle before each rise of `hsync`.
- R7: A pulse on `res_req` stores `res_req_words` as pending, with a value of 0 stored as 1. A later request overwrites the pending value before it is used. The pending value is taken at the next frame boundary. A request that arrives in the same cycle as a frame boundary is kept for the following boundary.
- R8: In a frame that takes a pending resolution, the sync region lasts max(V,2) lines, where V is the latched vertical sync count. Every line of that region is a dummy line: `hsync` follows the pulsed-line pattern and `valid` stays low.
- R9: `hres_out` changes only at the clock edge that ends the first dummy line of the sync region. It is therefore low-`vsync` stable for at least one full line before `vsync` rises.
- R10: `ctl_rst_n` is low exactly in the cycles where `hsync` is high during the first dummy line of a switching frame, and high in all other cycles.
- R11: The timing inputs are sampled at each frame boundary and at the first cycle after reset. Changing them mid-frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hsync_w | input | PW | Line sync gap in cycles (hsync low) |
| cfg_hback | input | PW | Horizontal back porch in cycles |
| cfg_hfront | input | PW | Horizontal front porch in cycles |
| cfg_vsync_l | input | LW | Vertical sync region in lines |
| cfg_vback | input | LW | Vertical back porch in lines |
| cfg_vact | input | LW | Active lines per frame |
| cfg_vfront | input | LW | Vertical front porch in lines |
| res_req | input | 1 | One-cycle request to change words per line |
| res_req_words | input | HW | Requested active words per line |
| type_req | input | TW | Requested data-type code |
| src_data | input | DW | Packed pixel word from the source |
| src_rd | output | 1 | Source word consumed this cycle |
| vsync | output | 1 | Frame strobe |
| hsync | output | 1 | Line strobe |
| valid | output | 1 | Word-valid strobe |
| data_out | output | DW | Packed pixel word toward the transmitter |
| hres_out | output | HW | Active words per line in effect |
| type_out | output | TW | Data-type code in effect |
| ctl_rst_n | output | 1 | Active-low controller reset request |

## Verification
The hardest case to reach from the ports is a resolution request that lands on the very last cycle of a frame. It must be deferred by a full frame, not taken at once. Close behind it are two requests inside one frame, where the later one must win. The bench keeps a cycle-exact model of the line and frame position. It uses that model's prediction of the frame boundary to fire a request in exactly that cycle, and the directed cases also cover a one-line sync region that must stretch to two dummy lines. Random configurations then mix mid-frame timing changes, zero and sub-minimum porches, and sparse requests against the same model.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  typedef enum logic [2:0] {
    VR_LOAD  = 3'd0,
    VR_SYNC  = 3'd1,
    VR_BACK  = 3'd2,
    VR_ACT   = 3'd3,
    VR_FRONT = 3'd4
  } vreg_e;

  function automatic vreg_e vreg_next(input vreg_e r);
    case (r)
      VR_SYNC: return VR_BACK;
      VR_BACK: return VR_ACT;
      VR_ACT:  return VR_FRONT;
      default: return VR_SYNC;
    endcase
  endfunction
endpackage

// File: rtl/lfg_vseq.sv
module lfg_vseq
  import lfg_pkg::*;
#(
  parameter int PW        = 8,
  parameter int LW        = 12,
  parameter int MIN_H     = 2,
  parameter int MIN_V     = 1,
  parameter int MIN_DUMMY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cfg_hsw,
  input  logic [PW-1:0] cfg_hbp,
  input  logic [PW-1:0] cfg_hfp,
  input  logic [LW-1:0] cfg_vsw,
  input  logic [LW-1:0] cfg_vbp,
  input  logic [LW-1:0] cfg_vact,
  input  logic [LW-1:0] cfg_vfp,
  input  logic          line_end,
  input  logic          sw_active,
  output logic [PW-1:0] hsw_q,
  output logic [PW-1:0] hbp_q,
  output logic [PW-1:0] hfp_q,
  output logic          load,
  output logic          frame_enter,
  output logic          sync_exit,
  output logic          first_sync_line,
  output logic          vsync,
  output logic          pulse_line,
  output logic          act_line
);
  localparam logic [PW-1:0] HMIN = PW'(MIN_H);
  localparam logic [LW-1:0] VMIN = LW'(MIN_V);
  localparam logic [LW-1:0] DMIN = LW'(MIN_DUMMY);

  function automatic logic [PW-1:0] hclamp(input logic [PW-1:0] v);
    return (v < HMIN) ? HMIN : v;
  endfunction

  function automatic logic [LW-1:0] vclamp(input logic [LW-1:0] v);
    return (v < VMIN) ? VMIN : v;
  endfunction

  vreg_e         reg_q;
  logic [LW-1:0] vcnt_q, vsw_q, vbp_q, vact_q, vfp_q, span;
  logic          last_line;

  always_comb begin
    case (reg_q)
      VR_SYNC:  span = (sw_active && vsw_q < DMIN) ? DMIN : vsw_q;
      VR_BACK:  span = vbp_q;
      VR_ACT:   span = vact_q;
      VR_FRONT: span = vfp_q;
      default:  span = LW'(1);
    endcase
  end

  assign last_line       = (vcnt_q == span - LW'(1));
  assign load            = (reg_q == VR_LOAD);
  assign frame_enter     = load || (reg_q == VR_FRONT && line_end && last_line);
  assign sync_exit       = (reg_q == VR_SYNC) && line_end && last_line;
  assign first_sync_line = (reg_q == VR_SYNC) && (vcnt_q == '0);
  assign vsync           = reg_q inside {VR_BACK, VR_ACT, VR_FRONT};
  assign act_line        = (reg_q == VR_ACT);
  assign pulse_line      = act_line || (reg_q == VR_SYNC && sw_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= VR_LOAD;
      vcnt_q <= '0;
      hsw_q  <= HMIN;
      hbp_q  <= HMIN;
      hfp_q  <= HMIN;
      vsw_q  <= VMIN;
      vbp_q  <= VMIN;
      vact_q <= VMIN;
      vfp_q  <= VMIN;
    end else if (frame_enter) begin
      reg_q  <= VR_SYNC;
      vcnt_q <= '0;
      hsw_q  <= hclamp(cfg_hsw);
      hbp_q  <= hclamp(cfg_hbp);
      hfp_q  <= hclamp(cfg_hfp);
      vsw_q  <= vclamp(cfg_vsw);
      vbp_q  <= vclamp(cfg_vbp);
      vact_q <= vclamp(cfg_vact);
      vfp_q  <= vclamp(cfg_vfp);
    end else if (line_end) begin
      if (last_line) begin
        reg_q  <= vreg_next(reg_q);
        vcnt_q <= '0;
      end else begin
        vcnt_q <= vcnt_q + LW'(1);
      end
    end
  end
endmodule

// File: rtl/lfg_hcount.sv
module lfg_hcount #(
  parameter int PW = 8,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [PW-1:0] hsw,
  input  logic [PW-1:0] hbp,
  input  logic [PW-1:0] hfp,
  input  logic [HW-1:0] hres,
  input  logic          pulse_line,
  input  logic          act_line,
  output logic          line_end,
  output logic          hsync,
  output logic          valid,
  output logic          type_win
);
  localparam int CW = ((HW > PW) ? HW : PW) + 2;

  logic [CW-1:0] pos_q, e_hsw, e_hbp, e_hfp, e_hres, line_len, act_lo, act_hi;

  assign e_hsw    = CW'(hsw);
  assign e_hbp    = CW'(hbp);
  assign e_hfp    = CW'(hfp);
  assign e_hres   = CW'(hres);
  assign line_len = e_hsw + e_hbp + e_hres + e_hfp;
  assign act_lo   = e_hsw + e_hbp;
  assign act_hi   = act_lo + e_hres;

  assign line_end = !hold && (pos_q == line_len - CW'(1));
  assign hsync    = pulse_line && (pos_q >= e_hsw);
  assign valid    = act_line && (pos_q >= act_lo) && (pos_q < act_hi);
  assign type_win = (pos_q + CW'(1)) < e_hsw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pos_q <= '0;
    else if (hold || line_end) pos_q <= '0;
    else                       pos_q <= pos_q + CW'(1);
  end
endmodule

// File: rtl/lfg_resreq.sv
module lfg_resreq #(
  parameter int              HW       = 16,
  parameter logic [HW-1:0]   DEF_HRES = 16'd8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [HW-1:0] req_words,
  input  logic          frame_enter,
  input  logic          sync_exit,
  input  logic          first_sync_line,
  input  logic          line_end,
  input  logic          hsync,
  output logic [HW-1:0] hres_q,
  output logic          sw_active,
  output logic          ctl_rst_n
);
  logic          pend_v;
  logic [HW-1:0] pend_w, tgt_q, req_fix;

  assign req_fix   = (req_words == '0) ? HW'(1) : req_words;
  assign ctl_rst_n = !(sw_active && first_sync_line && hsync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_w <= '0;
    end else if (req_valid) begin
      pend_v <= 1'b1;
      pend_w <= req_fix;
    end else if (frame_enter) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_active <= 1'b0;
      tgt_q     <= '0;
    end else if (frame_enter && pend_v) begin
      sw_active <= 1'b1;
      tgt_q     <= pend_w;
    end else if (sync_exit) begin
      sw_active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hres_q <= DEF_HRES;
    else if (sw_active && first_sync_line && line_end)
      hres_q <= tgt_q;
  end
endmodule

// File: rtl/lfg_typegate.sv
module lfg_typegate #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win,
  input  logic [TW-1:0] type_req,
  output logic [TW-1:0] type_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   type_q <= '0;
    else if (win) type_q <= type_req;
  end
endmodule

// File: rtl/line_frame_gen.sv
module line_frame_gen #(
  parameter int            DW        = 64,
  parameter int            HW        = 16,
  parameter int            PW        = 8,
  parameter int            LW        = 12,
  parameter int            TW        = 6,
  parameter logic [HW-1:0] DEF_HRES  = 16'd8,
  parameter int            MIN_H     = 2,
  parameter int            MIN_V     = 1,
  parameter int            MIN_DUMMY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cfg_hsync_w,
  input  logic [PW-1:0] cfg_hback,
  input  logic [PW-1:0] cfg_hfront,
  input  logic [LW-1:0] cfg_vsync_l,
  input  logic [LW-1:0] cfg_vback,
  input  logic [LW-1:0] cfg_vact,
  input  logic [LW-1:0] cfg_vfront,
  input  logic          res_req,
  input  logic [HW-1:0] res_req_words,
  input  logic [TW-1:0] type_req,
  input  logic [DW-1:0] src_data,
  output logic          src_rd,
  output logic          vsync,
  output logic          hsync,
  output logic          valid,
  output logic [DW-1:0] data_out,
  output logic [HW-1:0] hres_out,
  output logic [TW-1:0] type_out,
  output logic          ctl_rst_n
);
  logic [PW-1:0] hsw_q, hbp_q, hfp_q;
  logic load, frame_enter, sync_exit, first_sync_line, pulse_line, act_line;
  logic line_end, sw_active, type_win;

  lfg_vseq #(
    .PW(PW), .LW(LW), .MIN_H(MIN_H), .MIN_V(MIN_V), .MIN_DUMMY(MIN_DUMMY)
  ) u_vseq (
    .clk(clk), .rst_n(rst_n),
    .cfg_hsw(cfg_hsync_w), .cfg_hbp(cfg_hback), .cfg_hfp(cfg_hfront),
    .cfg_vsw(cfg_vsync_l), .cfg_vbp(cfg_vback), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfront),
    .line_end(line_end), .sw_active(sw_active),
    .hsw_q(hsw_q), .hbp_q(hbp_q), .hfp_q(hfp_q),
    .load(load), .frame_enter(frame_enter), .sync_exit(sync_exit),
    .first_sync_line(first_sync_line), .vsync(vsync),
    .pulse_line(pulse_line), .act_line(act_line)
  );

  lfg_hcount #(.PW(PW), .HW(HW)) u_hcount (
    .clk(clk), .rst_n(rst_n), .hold(load),
    .hsw(hsw_q), .hbp(hbp_q), .hfp(hfp_q), .hres(hres_out),
    .pulse_line(pulse_line), .act_line(act_line),
    .line_end(line_end), .hsync(hsync), .valid(valid), .type_win(type_win)
  );

  lfg_resreq #(.HW(HW), .DEF_HRES(DEF_HRES)) u_resreq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(res_req), .req_words(res_req_words),
    .frame_enter(frame_enter), .sync_exit(sync_exit),
    .first_sync_line(first_sync_line), .line_end(line_end), .hsync(hsync),
    .hres_q(hres_out), .sw_active(sw_active), .ctl_rst_n(ctl_rst_n)
  );

  lfg_typegate #(.TW(TW)) u_type (
    .clk(clk), .rst_n(rst_n), .win(type_win),
    .type_req(type_req), .type_q(type_out)
  );

  assign src_rd   = valid;
  assign data_out = valid ? src_data : '0;
endmodule

// File: rtl/lfg_chk.sv
module lfg_chk #(
  parameter int HW = 16,
  parameter int PW = 8,
  parameter int TW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vsync,
  input logic          hsync,
  input logic          valid,
  input logic          ctl_rst_n,
  input logic [HW-1:0] hres_out,
  input logic [TW-1:0] type_out
);
  logic [HW:0] run_q;
  logic [PW:0] bp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (valid) run_q <= run_q + (HW+1)'(1);
    else            run_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      bp_q <= '0;
    else if (!hsync)                 bp_q <= '0;
    else if (!valid && bp_q != '1)   bp_q <= bp_q + (PW+1)'(1);
  end

  p_valid_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> run_q == {1'b0, hres_out});

  p_valid_framed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> hsync && vsync);

  p_hs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> !$past(hsync, 2));

  p_back_porch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> bp_q >= (PW+1)'(2));

  p_front_porch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> hsync ##1 hsync);

  p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |-> !valid);

  p_type_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(type_out) |-> !hsync);

  p_type_pre_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> $stable(type_out));

  p_hres_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hres_out) |-> !vsync);

  p_hres_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> $stable(hres_out));

  p_ctl_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rst_n |-> hsync && !vsync && !valid);
endmodule

bind line_frame_gen lfg_chk #(.HW(HW), .PW(PW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync), .valid(valid),
  .ctl_rst_n(ctl_rst_n), .hres_out(hres_out), .type_out(type_out)
);

// File: tb/sim_line_frame_gen.sv
`timescale 1ns/1ps
module sim_line_frame_gen;
  localparam int DW = 64, HW = 16, PW = 8, LW = 12, TW = 6;
  localparam int DEFH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PW-1:0] cfg_hsync_w, cfg_hback, cfg_hfront;
  logic [LW-1:0] cfg_vsync_l, cfg_vback, cfg_vact, cfg_vfront;
  logic          res_req;
  logic [HW-1:0] res_req_words;
  logic [TW-1:0] type_req;
  logic [DW-1:0] src_data;
  logic          src_rd, vsync, hsync, valid, ctl_rst_n;
  logic [DW-1:0] data_out;
  logic [HW-1:0] hres_out;
  logic [TW-1:0] type_out;

  line_frame_gen #(.DW(DW), .HW(HW), .PW(PW), .LW(LW), .TW(TW), .DEF_HRES(16'(DEFH))) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_hsync_w(cfg_hsync_w), .cfg_hback(cfg_hback), .cfg_hfront(cfg_hfront),
    .cfg_vsync_l(cfg_vsync_l), .cfg_vback(cfg_vback), .cfg_vact(cfg_vact),
    .cfg_vfront(cfg_vfront), .res_req(res_req), .res_req_words(res_req_words),
    .type_req(type_req), .src_data(src_data), .src_rd(src_rd), .vsync(vsync),
    .hsync(hsync), .valid(valid), .data_out(data_out), .hres_out(hres_out),
    .type_out(type_out), .ctl_rst_n(ctl_rst_n)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // cycle-exact expectation state, built from the requirements
  int m_st, m_vc, m_hc, m_hsw, m_hbp, m_hfp, m_vsw, m_vbp, m_vact, m_vfp;
  int m_hres, m_pv, m_pval, m_sw, m_tgt, m_dt;
  int f_sw, f_vsw, f_tgt;
  bit m_fe_now;

  function automatic int hcl(input int v); return (v < 2) ? 2 : v; endfunction
  function automatic int vcl(input int v); return (v < 1) ? 1 : v; endfunction
  function automatic int f_len(); return m_hsw + m_hbp + m_hres + m_hfp; endfunction
  function automatic int f_span();
    case (m_st)
      1: return (m_sw != 0 && m_vsw < 2) ? 2 : m_vsw;
      2: return m_vbp;
      3: return m_vact;
      4: return m_vfp;
      default: return 1;
    endcase
  endfunction
  function automatic bit f_le(); return (m_st != 0) && (m_hc == f_len() - 1); endfunction
  function automatic bit f_last(); return m_vc == f_span() - 1; endfunction
  function automatic bit f_fe(); return (m_st == 0) || (m_st == 4 && f_le() && f_last()); endfunction

  task automatic chk(input string tag, input string nm, input logic [63:0] a, input logic [63:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s got=%0h exp=%0h (cycle %0d)", tag, nm, a, e, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_vc = 0; m_hc = 0;
      m_hsw = 2; m_hbp = 2; m_hfp = 2; m_vsw = 1; m_vbp = 1; m_vact = 1; m_vfp = 1;
      m_hres = DEFH; m_pv = 0; m_pval = 0; m_sw = 0; m_tgt = 0; m_dt = 0;
      f_sw = 0; f_vsw = 1; f_tgt = 0; m_fe_now = 0;
    end else begin
      bit le, last, fe, sx;
      int nhc;
      le = f_le(); last = f_last(); fe = f_fe();
      sx = (m_st == 1) && le && last;
      if (m_hc + 1 < m_hsw) m_dt = int'(type_req);
      if (m_sw != 0 && m_st == 1 && m_vc == 0 && le) m_hres = m_tgt;
      if (fe && m_pv != 0) begin
        m_sw = 1; m_tgt = m_pval; f_sw = 1; f_tgt = m_pval;
      end else if (sx) m_sw = 0;
      else if (fe) f_sw = 0;
      if (res_req) begin
        m_pv = 1; m_pval = (res_req_words == 0) ? 1 : int'(res_req_words);
      end else if (fe) m_pv = 0;
      nhc = (m_st == 0 || le) ? 0 : m_hc + 1;
      if (fe) begin
        m_hsw = hcl(int'(cfg_hsync_w)); m_hbp = hcl(int'(cfg_hback)); m_hfp = hcl(int'(cfg_hfront));
        m_vsw = vcl(int'(cfg_vsync_l)); m_vbp = vcl(int'(cfg_vback));
        m_vact = vcl(int'(cfg_vact)); m_vfp = vcl(int'(cfg_vfront));
        f_vsw = m_vsw;
        m_st = 1; m_vc = 0;
      end else if (le) begin
        if (last) begin m_st = (m_st == 4) ? 1 : m_st + 1; m_vc = 0; end
        else m_vc = m_vc + 1;
      end
      m_hc = nhc;
      m_fe_now = f_fe();
    end
  end

  bit prev_hs = 0, prev_vs = 0, rise_ok = 0;
  int dummies = 0, last_rise = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      chk("R1", "vsync", vsync, 0);   chk("R1", "hsync", hsync, 0);
      chk("R1", "valid", valid, 0);   chk("R1", "src_rd", src_rd, 0);
      chk("R1", "ctl_rst_n", ctl_rst_n, 1);
      chk("R1", "hres_out", hres_out, DEFH);
      chk("R1", "type_out", type_out, 0);
      prev_hs = 0; prev_vs = 0; rise_ok = 0; dummies = 0;
    end else if (!finished) begin
      bit pl, ehs, ev;
      pl  = (m_st == 3) || (m_st == 1 && m_sw != 0);
      ehs = pl && (m_hc >= m_hsw);
      ev  = (m_st == 3) && (m_hc >= m_hsw + m_hbp) && (m_hc < m_hsw + m_hbp + m_hres);
      chk("R4", "vsync", vsync, 64'(m_st >= 2));
      chk("R2,R8", "hsync", hsync, 64'(ehs));
      chk("R2,R3", "valid", valid, 64'(ev));
      chk("R5", "src_rd", src_rd, 64'(ev));
      chk("R5", "data_out", data_out, ev ? src_data : 64'd0);
      chk("R7,R9", "hres_out", hres_out, 64'(m_hres));
      chk("R6", "type_out", type_out, 64'(m_dt));
      chk("R10", "ctl_rst_n", ctl_rst_n, 64'(!(m_sw != 0 && m_st == 1 && m_vc == 0 && ehs)));
      // dummy pulse count and applied resolution at the end of the sync region
      if (hsync && !prev_hs && !vsync) dummies++;
      if (vsync && !prev_vs) begin
        chk("R8", "dummy_pulses", dummies, f_sw != 0 ? ((f_vsw < 2) ? 2 : f_vsw) : 0);
        if (f_sw != 0) chk("R7", "hres_taken", hres_out, f_tgt);
        dummies = 0; rise_ok = 0;
      end
      // line period inside the open part of the frame
      if (hsync && !prev_hs && vsync) begin
        if (rise_ok) chk("R3,R11", "line_period", cyc - last_rise, f_len());
        rise_ok = 1; last_rise = cyc;
      end
      if (!vsync) rise_ok = 0;
      prev_hs = hsync; prev_vs = vsync;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wait_vs(input int n); repeat (n) @(posedge vsync); #1; endtask
  task automatic set_cfg(input int s, input int b, input int f, input int vs, input int vb, input int va, input int vf);
    cfg_hsync_w = PW'(s); cfg_hback = PW'(b); cfg_hfront = PW'(f);
    cfg_vsync_l = LW'(vs); cfg_vback = LW'(vb); cfg_vact = LW'(va); cfg_vfront = LW'(vf);
  endtask
  task automatic request(input int w);
    res_req = 1'b1; res_req_words = HW'(w); tick(); res_req = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      type_req = TW'($urandom);
      src_data = {$urandom, $urandom};
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int hold_w;
    void'($urandom(32'd20240611));
    res_req = 0; res_req_words = 0; type_req = 0; src_data = 0;
    set_cfg(3, 2, 2, 2, 1, 3, 1);
    repeat (4) tick();
    rst_n = 1'b1;
    // directed: nominal timing (R2, R4)
    wait_vs(2);
    // directed: sub-minimum programming raised to limits (R3, R4)
    set_cfg(0, 1, 0, 0, 0, 0, 0);
    wait_vs(3);
    // directed: one-line sync region stretched for a switch (R8, R9, R10)
    set_cfg(2, 3, 2, 1, 1, 2, 1);
    request(5);
    wait_vs(3);
    // directed: two requests in one frame, later one wins (R7)
    request(6); repeat (7) tick(); request(11);
    wait_vs(3);
    chk("R7", "latest_wins", hres_out, 11);
    // directed: request on the frame boundary cycle is deferred (R7)
    hold_w = int'(hres_out);
    while (!m_fe_now) tick();
    request(7);
    wait_vs(1);
    chk("R7", "boundary_deferred", hres_out, hold_w);
    wait_vs(1);
    chk("R7", "boundary_taken", hres_out, 7);
    // directed: zero request stored as one word (R7), longer sync region (R8)
    set_cfg(2, 2, 2, 3, 1, 2, 1);
    request(0);
    wait_vs(3);
    chk("R7", "zero_req", hres_out, 1);
    // directed: mid-frame config change waits for next frame (R11)
    wait_vs(1); repeat (5) tick();
    set_cfg(4, 4, 3, 2, 2, 3, 2);
    wait_vs(2);
    // random mix
    for (int it = 0; it < 30; it++) begin
      int n;
      set_cfg($urandom % 5, $urandom % 5, $urandom % 5, $urandom % 4,
              $urandom % 3, $urandom % 5, $urandom % 3);
      n = 100 + ($urandom % 300);
      for (int c = 0; c < n; c++) begin
        if ($urandom % 120 == 0) request($urandom % 13);
        else tick();
      end
    end
    wait_vs(2);
    repeat (4) tick();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule